// File: doc/BRIEF.md
# ADC Result Threshold Comparator

This block watches the stream of finished analog-to-digital conversion results and tests each one against an 8-bit threshold set by software. When the test passes, it sets a sticky flag. It works the same way for any conversion source. It sits beside the result queue rather than behind it, so it reacts to every result the converter produces, including results the queue later drops because it is full.

Software picks one of two conditions with a single select bit:

- **At-or-above:** the upper result bits are greater than or equal to the threshold.
- **Below:** the upper result bits are strictly less than the threshold.

The two least significant result bits never take part. Software can mask the flag onto an interrupt request line and clears the flag with a one-cycle pulse.

Top module: `adc_window_cmp`

## Requirements
- R1: While `rst` is high at a clock edge, `cmp_flag` becomes 0 after that edge, and `cmp_irq` is then 0.
- R2: With `cmp_en` at 0, no result sets `cmp_flag`, whatever its value.
- R3: Only `res_data[9:2]` is compared with `cmp_thresh[7:0]`. Bits 1:0 have no effect on the outcome.
- R4: With `cmp_ge_sel` at 1, a qualified result whose upper bits are greater than or equal to `cmp_thresh` sets `cmp_flag`. Equality counts as a hit.
- R5: With `cmp_ge_sel` at 0, a qualified result whose upper bits are strictly less than `cmp_thresh` sets `cmp_flag`. Equality is not a hit.
- R6: A result is evaluated only in cycles where `res_valid` is 1. `res_data` in other cycles has no effect.
- R7: Once set, `cmp_flag` stays 1 through any number of non-matching results until `flag_clr` is pulsed.
- R8: `flag_clr` at a clock edge clears `cmp_flag`. If a hit arrives at the same edge, the hit wins and the flag stays 1.
- R9: `cmp_irq` equals `cmp_flag AND irq_en` in every cycle, with no added delay.
- R10: A hit shows on `cmp_flag` right after the clock edge where the qualified result is sampled, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Strobe marking a finished conversion result |
| res_data | input | 10 | Conversion result |
| cmp_en | input | 1 | Enables the comparison |
| cmp_ge_sel | input | 1 | Condition select: 1 = at-or-above, 0 = below |
| cmp_thresh | input | 8 | Threshold compared with the result's upper bits |
| irq_en | input | 1 | Lets the flag drive the interrupt request |
| flag_clr | input | 1 | Clear pulse for the sticky flag |
| cmp_flag | output | 1 | Sticky comparison hit flag |
| cmp_irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear pulse and a hit arriving at the same edge, because the outcome depends on which of the two wins. The stimulus steers straight into that collision with a matching result and also pairs a clear with a non-matching result.

The boundary cases are covered the same way:
- results whose upper bits equal the threshold under both conditions;
- threshold extremes 0 and 255;
- results that differ only in bits 1:0, which must not change the outcome.

A pseudo-random sweep then mixes every control input, and a behavioural model checks both outputs on every cycle.

// File: rtl/adc_wcmp_pkg.sv
package adc_wcmp_pkg;

    typedef enum logic {
        WCMP_BELOW       = 1'b0,
        WCMP_AT_OR_ABOVE = 1'b1
    } wcmp_cond_e;

    typedef struct packed {
        logic qualified;
        logic fire;
    } wcmp_event_t;

endpackage

// File: rtl/wcmp_slice.sv
module wcmp_slice
    import adc_wcmp_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CMP_W = 8
) (
    input  logic             qualify,
    input  logic [RES_W-1:0] res_data,
    input  logic [CMP_W-1:0] thresh,
    input  wcmp_cond_e       cond,
    output wcmp_event_t      evt
);
    localparam int DROP_W = (RES_W > CMP_W) ? RES_W - CMP_W : 0;

    logic [CMP_W-1:0] upper;

    generate
        if (DROP_W > 0) begin : g_trim
            logic [DROP_W-1:0] unused_low;
            assign upper      = res_data[RES_W-1 -: CMP_W];
            assign unused_low = res_data[DROP_W-1:0];
        end else begin : g_widen
            assign upper = CMP_W'(res_data);
        end
    endgenerate

    logic below;
    assign below = (upper < thresh);

    always_comb begin
        evt.qualified = qualify;
        unique case (cond)
            WCMP_AT_OR_ABOVE: evt.fire = qualify && !below;
            default:          evt.fire = qualify && below;
        endcase
    end
endmodule

// File: rtl/wcmp_flag.sv
module wcmp_flag
    import adc_wcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wcmp_event_t evt,
    input  logic        clr,
    output logic        flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (evt.fire)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/wcmp_irq_gate.sv
module wcmp_irq_gate (
    input  logic flag,
    input  logic enable,
    output logic req
);
    assign req = flag & enable;
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
    import adc_wcmp_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CMP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             cmp_en,
    input  logic             cmp_ge_sel,
    input  logic [CMP_W-1:0] cmp_thresh,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             cmp_flag,
    output logic             cmp_irq
);
    wcmp_event_t evt;
    wcmp_cond_e  cond;

    assign cond = wcmp_cond_e'(cmp_ge_sel);

    wcmp_slice #(.RES_W(RES_W), .CMP_W(CMP_W)) slice_i (
        .qualify  (res_valid & cmp_en),
        .res_data (res_data),
        .thresh   (cmp_thresh),
        .cond     (cond),
        .evt      (evt)
    );

    wcmp_flag flag_i (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (flag_clr),
        .flag (cmp_flag)
    );

    wcmp_irq_gate gate_i (
        .flag   (cmp_flag),
        .enable (irq_en),
        .req    (cmp_irq)
    );
endmodule

// File: rtl/adc_window_cmp_chk.sv
module adc_window_cmp_chk #(
    parameter int RES_W = 10,
    parameter int CMP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data,
    input logic             cmp_en,
    input logic             cmp_ge_sel,
    input logic [CMP_W-1:0] cmp_thresh,
    input logic             irq_en,
    input logic             flag_clr,
    input logic             cmp_flag,
    input logic             cmp_irq
);
    logic [CMP_W-1:0] up;
    assign up = res_data[RES_W-1 -: CMP_W];

    assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !cmp_flag);

    assert_disabled_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!cmp_en && !flag_clr) |=> $stable(cmp_flag));

    assert_ge_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cmp_en && cmp_ge_sel && (up >= cmp_thresh)) |=> cmp_flag);

    assert_lt_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cmp_en && !cmp_ge_sel && (up < cmp_thresh)) |=> cmp_flag);

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !flag_clr) |=> $stable(cmp_flag));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_flag && !flag_clr) |=> cmp_flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(res_valid && cmp_en)) |=> !cmp_flag);

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
        cmp_irq == (cmp_flag && irq_en));
endmodule

bind adc_window_cmp adc_window_cmp_chk #(.RES_W(RES_W), .CMP_W(CMP_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .cmp_en     (cmp_en),
    .cmp_ge_sel (cmp_ge_sel),
    .cmp_thresh (cmp_thresh),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .cmp_flag   (cmp_flag),
    .cmp_irq    (cmp_irq)
);

// File: tb/adc_window_cmp_tb_top.sv
`timescale 1ns/1ps
module adc_window_cmp_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       res_valid;
    logic [9:0] res_data;
    logic       cmp_en;
    logic       cmp_ge_sel;
    logic [7:0] cmp_thresh;
    logic       irq_en;
    logic       flag_clr;
    logic       cmp_flag;
    logic       cmp_irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  model_flag = 1'b0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    adc_window_cmp dut_i (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .cmp_en(cmp_en), .cmp_ge_sel(cmp_ge_sel), .cmp_thresh(cmp_thresh),
        .irq_en(irq_en), .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drives one cycle from a negedge, checks pre-edge and post-edge state.
    task automatic step(input bit v, input int d, input bit en, input bit ge,
                        input int th, input bit ie, input bit clr, input string req);
        bit hit;
        res_valid = v; res_data = 10'(d); cmp_en = en; cmp_ge_sel = ge;
        cmp_thresh = 8'(th); irq_en = ie; flag_clr = clr;
        #1;
        check({req, "/R10 flag before edge"}, cmp_flag, model_flag);
        check({req, "/R9 irq"}, cmp_irq, model_flag & ie);
        @(posedge clk);
        hit = v && en && (ge ? ((d / 4) >= th) : ((d / 4) < th));
        if (rst) model_flag = 1'b0;
        else if (hit) model_flag = 1'b1;
        else if (clr) model_flag = 1'b0;
        @(negedge clk);
        check({req, " flag"}, cmp_flag, model_flag);
        check({req, "/R9 irq after"}, cmp_irq, model_flag & ie);
    endtask

    task automatic clear_flag();
        step(0, 0, 1, 1, 0, 1, 1, "R8 clear");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; res_valid = 0; res_data = 0; cmp_en = 0; cmp_ge_sel = 0;
        cmp_thresh = 0; irq_en = 1; flag_clr = 0;
        @(negedge clk);
        // R1: reset with a matching result pending
        step(1, 10'h3FF, 1, 1, 0, 1, 0, "R1 reset");
        rst = 1'b0;

        // R2: disabled compare never sets
        step(1, 10'h3FF, 0, 1, 0, 1, 0, "R2 disabled ge");
        step(1, 0, 0, 0, 255, 1, 0, "R2 disabled lt");

        // R4: equality hits in at-or-above mode
        step(1, 10'h200, 1, 1, 8'h80, 1, 0, "R4 equal");
        clear_flag();
        step(1, 10'h1FC, 1, 1, 8'h80, 1, 0, "R4 below no hit");
        step(1, 10'h3FC, 1, 1, 8'hFF, 1, 0, "R4 thresh 255");
        clear_flag();

        // R3: low bits must not matter
        step(1, 10'h1FF, 1, 1, 8'h80, 1, 0, "R3 low bits set below");
        step(1, 10'h203, 1, 1, 8'h80, 1, 0, "R3 low bits set equal");
        clear_flag();
        step(1, 10'h203, 1, 0, 8'h81, 1, 0, "R3 lt with low bits");
        clear_flag();

        // R5: strictly below
        step(1, 10'h200, 1, 0, 8'h80, 1, 0, "R5 equal no hit");
        step(1, 10'h203, 1, 0, 8'h80, 1, 0, "R5 equal low bits no hit");
        step(1, 0, 1, 0, 0, 1, 0, "R5 thresh 0 no hit");
        step(1, 10'h1FC, 1, 0, 8'h80, 1, 0, "R5 below hit");
        clear_flag();

        // R6: strobe low ignores data
        step(0, 10'h3FF, 1, 1, 0, 1, 0, "R6 no strobe");
        step(0, 0, 1, 0, 255, 1, 0, "R6 no strobe lt");

        // R7: sticky through misses
        step(1, 10'h3FF, 1, 1, 8'h10, 1, 0, "R7 set");
        step(1, 0, 1, 1, 8'h10, 1, 0, "R7 miss keeps");
        step(1, 0, 0, 1, 8'h10, 1, 0, "R7 disabled keeps");
        step(0, 0, 1, 1, 8'h10, 0, 0, "R7 idle keeps masked");

        // R8: clear alone, clear colliding with hit, clear with miss
        step(0, 0, 1, 1, 8'h10, 1, 1, "R8 clear alone");
        step(1, 10'h3FF, 1, 1, 8'h10, 1, 0, "R8 set again");
        step(1, 10'h3FF, 1, 1, 8'h10, 1, 1, "R8 clear vs hit");
        step(1, 0, 1, 1, 8'h10, 1, 1, "R8 clear vs miss");

        // R9: masking
        step(1, 10'h3FF, 1, 1, 0, 0, 0, "R9 masked set");
        step(0, 0, 1, 1, 0, 1, 0, "R9 unmasked");
        clear_flag();

        // Sweep
        begin
            logic [31:0] lfsr = 32'hACE1_1234;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                step(lfsr[0], int'(lfsr[13:4]), lfsr[1] | lfsr[2], lfsr[3],
                     int'(lfsr[21:14]), lfsr[22], lfsr[23] & lfsr[24], "R4/R5 sweep");
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule